// File: doc/BRIEF.md
# On-Chip Bus Address Router with Per-Target Wait States

This block sits between the CPU's memory port and three destinations in a 24-bit linear byte address space: a 6 KB on-chip extension RAM, a 256-byte on-chip peripheral window, and the external memory interface. It decodes each accepted access, raises exactly one target select, generates byte-lane enables, and hands the CPU a ready strobe once the target's wait states have passed. Read data from the selected target is routed back to the CPU.

Both on-chip windows depend on one window-enable input, which the integrator wires to bit 2 of the system control register. When that input is low, addresses inside either window are sent to the external interface, which does its own chip-select matching and timing and reports completion through its own ready input.

Only one access is outstanding at a time. A request is taken only while the router is idle, and all access attributes are captured at that moment and held until the access completes.

Top module: `bus_route_decoder`

## Requirements
- R1: With `onchip_win_en` = 1, an access to any byte address from 0x00D000 to 0x00E7FF inclusive raises `xram_sel` and no other select.
- R2: With `onchip_win_en` = 1, an access to any byte address from 0x00EF00 to 0x00EFFF inclusive raises `peri_sel` and no other select.
- R3: Every other address, and every address in either window while `onchip_win_en` = 0, raises `ext_sel` only.
- R4: Lane enables `tgt_be` (bit 0 = low byte, bit 1 = high byte): a word access gives 2'b11 and drives `tgt_addr` with bit 0 forced to 0; a byte access gives 2'b01 when address bit 0 is 0 and 2'b10 when it is 1, with the address passed unchanged.
- R5: An extension RAM access takes zero wait states: `cpu_ready` is high in the first cycle after the request is accepted.
- R6: A peripheral access takes exactly two wait states: `cpu_ready` is low in the first and second cycles after acceptance and high in the third.
- R7: An external access completes in the first cycle in which `ext_ready` is high while `ext_sel` is high; `cpu_ready` follows `ext_ready` combinationally during that access.
- R8: At most one select is high in any cycle, and the target address, lane enables, write flag and write data stay constant for the whole access.
- R9: A request presented while an access is in progress is ignored: the current access, its address and its completion cycle are unchanged, and no access follows it.
- R10: In the ready cycle of a read, `cpu_rdata` equals the read data input of the selected target.
- R11: After reset, and in the cycle after any ready, no select and no ready are high (no turnaround or tristate cycle is added).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| onchip_win_en | input | 1 | Window enable (system control bit 2) |
| req_valid | input | 1 | CPU access request, taken when idle |
| req_addr | input | 24 | Byte address of the request |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ready` on reads |
| xram_sel | output | 1 | Extension RAM selected |
| peri_sel | output | 1 | Peripheral window selected |
| ext_sel | output | 1 | External interface selected |
| tgt_addr | output | 24 | Captured access address (word-aligned for words) |
| tgt_be | output | 2 | Byte-lane enables |
| tgt_write | output | 1 | Captured write flag |
| tgt_wdata | output | 16 | Captured write data |
| xram_rdata | input | 16 | Read data from extension RAM |
| peri_rdata | input | 16 | Read data from peripheral window |
| ext_rdata | input | 16 | Read data from external interface |
| ext_ready | input | 1 | External interface completion |

## Verification
A request is captured on the clock edge that accepts it, so the selects, address and lane enables are due in the first cycle after that edge, and `cpu_ready` is due in cycle 1 for the RAM, cycle 3 for the peripheral window, and in the cycle the bench raises `ext_ready` for external accesses. The bench counts cycles from acceptance, samples every output half a period after each edge, and compares the cycle in which ready first appears with the cycle it predicts; it then checks that the cycle after ready is idle. Boundary addresses of both windows are run with the enable high and low, and a second request is injected mid-access to show it leaves the access untouched.

// File: rtl/bus_route_pkg.sv
// Shared widths, target encoding and the captured-access record for the
// bus router. Assumes a 16-bit data path split into two byte lanes.
package bus_route_pkg;

    localparam int ADDR_W   = 24;
    localparam int DATA_W   = 16;
    localparam int LANES    = DATA_W / 8;
    localparam int LANE_SEL = (LANES > 1) ? $clog2(LANES) : 1;

    // Destination of an access; the numeric value indexes the select vector.
    typedef enum logic [1:0] {
        TGT_EXT  = 2'd0,
        TGT_XRAM = 2'd1,
        TGT_PERI = 2'd2
    } tgt_e;

    localparam int NUM_TGT = 3;

    // Everything about an access that is fixed at acceptance.
    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } acc_t;

endpackage

// File: rtl/route_window_decode.sv
// Maps a byte address onto one of the three targets.
// Assumes the two on-chip windows are disjoint, so no priority is needed;
// when the window enable is low both windows fall through to external.
module route_window_decode
    import bus_route_pkg::*;
#(
    parameter logic [ADDR_W-1:0] XRAM_LO = 24'h00D000,
    parameter logic [ADDR_W-1:0] XRAM_HI = 24'h00E7FF,
    parameter logic [ADDR_W-1:0] PERI_LO = 24'h00EF00,
    parameter logic [ADDR_W-1:0] PERI_HI = 24'h00EFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              win_en,
    output tgt_e              tgt
);

    logic in_xram;
    logic in_peri;

    // Range compare for each enabled on-chip window.
    always_comb begin
        in_xram = win_en && (addr >= XRAM_LO) && (addr <= XRAM_HI);
        in_peri = win_en && (addr >= PERI_LO) && (addr <= PERI_HI);
    end

    // Pick the target; anything not claimed on chip goes outside.
    always_comb begin
        if (in_xram)      tgt = TGT_XRAM;
        else if (in_peri) tgt = TGT_PERI;
        else              tgt = TGT_EXT;
    end

    // R2/R1: the two window compares must never both claim an address.
    always_comb begin
        a_r2_windows_disjoint: assert (!(in_xram && in_peri));
    end

endmodule

// File: rtl/route_lane_gen.sv
// Builds byte-lane enables and the lane-aligned address.
// Assumes word accesses cover every lane and byte accesses pick one lane
// from the low address bits.
module route_lane_gen
    import bus_route_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    output logic [ADDR_W-1:0] aligned,
    output logic [LANES-1:0]  be
);

    // One enable per lane: all lanes for a word, the addressed lane for a byte.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign be[l] = word || (addr[LANE_SEL-1:0] == LANE_SEL'(l));
    end

    // Word accesses drop the lane-select bits from the address.
    always_comb begin
        aligned = addr;
        if (word) aligned[LANE_SEL-1:0] = '0;
    end

endmodule

// File: rtl/route_access_seq.sv
// Accepts one access at a time, holds its attributes, and counts the
// target's wait states before raising ready. Assumes the external target
// signals its own completion; on-chip targets use fixed wait counts.
module route_access_seq
    import bus_route_pkg::*;
#(
    parameter int XRAM_WAITS = 0,
    parameter int PERI_WAITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  acc_t req_acc,
    input  logic ext_ready,
    output logic busy,
    output acc_t cur,
    output logic ready
);

    localparam int MAX_W = (XRAM_WAITS > PERI_WAITS) ? XRAM_WAITS : PERI_WAITS;
    localparam int CNT_W = (MAX_W > 0) ? $clog2(MAX_W + 1) : 1;

    logic [CNT_W-1:0] cnt;
    logic             accept;

    // Wait count to load for a given target.
    function automatic logic [CNT_W-1:0] waits_for(input tgt_e t);
        case (t)
            TGT_XRAM: waits_for = CNT_W'(XRAM_WAITS);
            TGT_PERI: waits_for = CNT_W'(PERI_WAITS);
            default:  waits_for = '0;
        endcase
    endfunction

    // A request is taken only while nothing is outstanding.
    assign accept = req_valid && !busy;

    // Completion: external follows its own strobe, on-chip waits for zero.
    always_comb begin
        if (!busy)                 ready = 1'b0;
        else if (cur.tgt == TGT_EXT) ready = ext_ready;
        else                       ready = (cnt == '0);
    end

    // Capture the access, count down waits, release after ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            cur  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cnt  <= waits_for(req_acc.tgt);
            cur  <= req_acc;
        end else if (busy) begin
            if (ready)            busy <= 1'b0;
            else if (cnt != '0)   cnt  <= cnt - 1'b1;
        end
    end

    // R8/R9: nothing about the access changes until it completes.
    a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ready) |=> (busy && $stable(cur)));

    // R11: the cycle after ready is idle.
    a_r11_release_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !busy);

    if (XRAM_WAITS == 0) begin : g_xram_zero
        // R5: a zero-wait target completes in its first access cycle.
        a_r5_xram_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && req_acc.tgt == TGT_XRAM) |=> ready);
    end

    if (PERI_WAITS > 0) begin : g_peri_wait
        // R6: a waited target is never ready in its first access cycle.
        a_r6_peri_not_first: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && req_acc.tgt == TGT_PERI) |=> !ready);
    end

endmodule

// File: rtl/bus_route_decoder.sv
// Top of the bus router: decodes the request, builds lane enables,
// sequences the access and returns ready and read data to the CPU.
// Assumes one outstanding access and a CPU that waits for ready.
module bus_route_decoder
    import bus_route_pkg::*;
#(
    parameter logic [ADDR_W-1:0] XRAM_LO    = 24'h00D000,
    parameter logic [ADDR_W-1:0] XRAM_HI    = 24'h00E7FF,
    parameter logic [ADDR_W-1:0] PERI_LO    = 24'h00EF00,
    parameter logic [ADDR_W-1:0] PERI_HI    = 24'h00EFFF,
    parameter int                XRAM_WAITS = 0,
    parameter int                PERI_WAITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              onchip_win_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              xram_sel,
    output logic              peri_sel,
    output logic              ext_sel,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [LANES-1:0]  tgt_be,
    output logic              tgt_write,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic [DATA_W-1:0] xram_rdata,
    input  logic [DATA_W-1:0] peri_rdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              ext_ready
);

    tgt_e              dec_tgt;
    logic [ADDR_W-1:0] dec_addr;
    logic [LANES-1:0]  dec_be;
    acc_t              req_acc;
    acc_t              cur;
    logic              busy;
    logic [NUM_TGT-1:0] sel_vec;

    route_window_decode #(
        .XRAM_LO (XRAM_LO),
        .XRAM_HI (XRAM_HI),
        .PERI_LO (PERI_LO),
        .PERI_HI (PERI_HI)
    ) u_decode (
        .addr   (req_addr),
        .win_en (onchip_win_en),
        .tgt    (dec_tgt)
    );

    route_lane_gen u_lanes (
        .addr    (req_addr),
        .word    (req_word),
        .aligned (dec_addr),
        .be      (dec_be)
    );

    // Bundle the decoded request for capture.
    always_comb begin
        req_acc.tgt   = dec_tgt;
        req_acc.addr  = dec_addr;
        req_acc.be    = dec_be;
        req_acc.write = req_write;
        req_acc.wdata = req_wdata;
    end

    route_access_seq #(
        .XRAM_WAITS (XRAM_WAITS),
        .PERI_WAITS (PERI_WAITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_acc   (req_acc),
        .ext_ready (ext_ready),
        .busy      (busy),
        .cur       (cur),
        .ready     (cpu_ready)
    );

    // One select per target, high only while that target's access runs.
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_sel
        assign sel_vec[t] = busy && (cur.tgt == tgt_e'(t));
    end

    assign ext_sel   = sel_vec[TGT_EXT];
    assign xram_sel  = sel_vec[TGT_XRAM];
    assign peri_sel  = sel_vec[TGT_PERI];
    assign tgt_addr  = cur.addr;
    assign tgt_be    = cur.be;
    assign tgt_write = cur.write;
    assign tgt_wdata = cur.wdata;

    // Return the read data of the target being accessed.
    always_comb begin
        case (cur.tgt)
            TGT_XRAM: cpu_rdata = xram_rdata;
            TGT_PERI: cpu_rdata = peri_rdata;
            default:  cpu_rdata = ext_rdata;
        endcase
    end

    // R8: never more than one target selected.
    a_r8_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xram_sel, peri_sel, ext_sel}));

    // R7: an external access cannot complete without the external strobe.
    a_r7_ext_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && cpu_ready) |-> ext_ready);

endmodule

// File: tb/bus_route_decoder_bench.sv
module bus_route_decoder_bench;
    import bus_route_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        onchip_win_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        cpu_ready;
    logic [15:0] cpu_rdata;
    logic        xram_sel, peri_sel, ext_sel;
    logic [23:0] tgt_addr;
    logic [1:0]  tgt_be;
    logic        tgt_write;
    logic [15:0] tgt_wdata;
    logic [15:0] xram_rdata = '0, peri_rdata = '0, ext_rdata = '0;
    logic        ext_ready = 1'b0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bus_route_decoder u_bus_route_decoder (
        .clk(clk), .rst_n(rst_n), .onchip_win_en(onchip_win_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_word(req_word),
        .req_write(req_write), .req_wdata(req_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .xram_sel(xram_sel), .peri_sel(peri_sel), .ext_sel(ext_sel),
        .tgt_addr(tgt_addr), .tgt_be(tgt_be), .tgt_write(tgt_write),
        .tgt_wdata(tgt_wdata), .xram_rdata(xram_rdata),
        .peri_rdata(peri_rdata), .ext_rdata(ext_rdata), .ext_ready(ext_ready)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected select vector {xram, peri, ext} from the requirements R1-R3 rules.
    function automatic logic [2:0] exp_sel(input logic [23:0] a, input bit en);
        if (en && a >= 24'h00D000 && a <= 24'h00E7FF) return 3'b100;
        if (en && a >= 24'h00EF00 && a <= 24'h00EFFF) return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic [1:0] exp_be(input logic [23:0] a, input bit word);
        if (word) return 2'b11;
        return a[0] ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [23:0] exp_addr(input logic [23:0] a, input bit word);
        return word ? {a[23:1], 1'b0} : a;
    endfunction

    // Run one access and check decode, lanes, timing, data and release.
    task automatic run_access(input logic [23:0] a, input bit word, input bit wr,
                              input bit en, input int dext, input bit poke);
        logic [2:0]  es;
        int          exp_n;
        int          got_n;
        logic [15:0] exp_rd;
        logic [15:0] wd;
        wd = 16'($urandom);
        @(negedge clk);
        onchip_win_en = en;
        req_valid = 1'b1; req_addr = a; req_word = word;
        req_write = wr; req_wdata = wd;
        xram_rdata = 16'($urandom); peri_rdata = 16'($urandom);
        ext_rdata = 16'($urandom);
        es = exp_sel(a, en);
        exp_n  = es[2] ? 1 : (es[1] ? 3 : dext);
        exp_rd = es[2] ? xram_rdata : (es[1] ? peri_rdata : ext_rdata);
        got_n = 0;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            req_valid = 1'b0;
            ext_ready = es[0] && (n == dext);
            if (poke && n == 1) begin
                // R9: second request while busy, aimed at another window.
                req_valid = 1'b1; req_addr = 24'h00D100; req_word = 1'b0;
                onchip_win_en = 1'b1;
            end
            #1;
            if (n == 1) begin
                check({xram_sel, peri_sel, ext_sel} == es, "R1/R2/R3 select",
                      {29'd0, xram_sel, peri_sel, ext_sel}, {29'd0, es});
                check(tgt_be == exp_be(a, word), "R4 lanes",
                      {30'd0, tgt_be}, {30'd0, exp_be(a, word)});
                check(tgt_addr == exp_addr(a, word), "R4 address",
                      {8'd0, tgt_addr}, {8'd0, exp_addr(a, word)});
            end
            if (poke && n == 2) begin
                check(tgt_addr == exp_addr(a, word) && !xram_sel, "R9 ignored request",
                      {8'd0, tgt_addr}, {8'd0, exp_addr(a, word)});
                check(tgt_write == wr && tgt_wdata == wd, "R8 attributes held",
                      {15'd0, tgt_write, tgt_wdata}, {15'd0, wr, wd});
            end
            if (cpu_ready && got_n == 0) begin
                got_n = n;
                if (!wr)
                    check(cpu_rdata == exp_rd, "R10 read data",
                          {16'd0, cpu_rdata}, {16'd0, exp_rd});
            end
            if (got_n != 0) break;
        end
        check(got_n == exp_n, es[2] ? "R5 ready cycle" : (es[1] ? "R6 ready cycle"
              : "R7 ready cycle"), got_n, exp_n);
        @(negedge clk);
        req_valid = 1'b0;
        ext_ready = 1'b0;
        #1;
        check({xram_sel, peri_sel, ext_sel, cpu_ready} == 4'b0, "R11 idle after ready",
              {28'd0, xram_sel, peri_sel, ext_sel, cpu_ready}, 32'd0);
    endtask

    // Watchdog: a hung run is a failure that still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                tests++;
                $display("FAIL watchdog: actual %0d expected below 100000", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [23:0] edges [8];
        void'($urandom(32'd1729));
        edges[0] = 24'h00CFFF; edges[1] = 24'h00D000;
        edges[2] = 24'h00E7FF; edges[3] = 24'h00E800;
        edges[4] = 24'h00EEFF; edges[5] = 24'h00EF00;
        edges[6] = 24'h00EFFF; edges[7] = 24'h00F000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: reset state.
        check({xram_sel, peri_sel, ext_sel, cpu_ready} == 4'b0, "R11 reset state",
              {28'd0, xram_sel, peri_sel, ext_sel, cpu_ready}, 32'd0);

        // Window boundaries with the enable high and low (R1, R2, R3).
        for (int e = 0; e < 2; e++)
            for (int i = 0; i < 8; i++)
                run_access(edges[i], 1'b0, 1'b0, e[0], 2, 1'b0);

        // R4: odd byte, even byte, word at odd address in each window.
        run_access(24'h00D001, 1'b0, 1'b1, 1'b1, 1, 1'b0);
        run_access(24'h00EF02, 1'b0, 1'b0, 1'b1, 1, 1'b0);
        run_access(24'h00EF11, 1'b1, 1'b1, 1'b1, 1, 1'b0);
        run_access(24'h123457, 1'b1, 1'b0, 1'b0, 4, 1'b0);

        // R9: request injected during a peripheral and an external access.
        run_access(24'h00EF40, 1'b1, 1'b1, 1'b1, 1, 1'b1);
        run_access(24'hABC000, 1'b0, 1'b0, 1'b1, 3, 1'b1);

        // Back-to-back accesses with no gap.
        run_access(24'h00D800, 1'b1, 1'b0, 1'b1, 1, 1'b0);
        run_access(24'h00D802, 1'b1, 1'b0, 1'b1, 1, 1'b0);

        // Random accesses, biased toward the on-chip region.
        for (int k = 0; k < 60; k++) begin
            logic [23:0] a;
            a = ($urandom_range(0, 3) == 0) ? 24'($urandom)
                                            : 24'h00C000 + 24'($urandom_range(0, 16'h3FFF));
            run_access(a, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) != 0),
                       $urandom_range(1, 5), 1'($urandom_range(0, 4) == 0));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule